// File: doc/BRIEF.md
# Store Queue with Load Address Check

This block keeps the stores that are in flight in program order and answers, for each load, whether an older store in the queue decides the load's value. A store takes a slot when it is dispatched and receives a queue position. Its address, access size and data arrive later through a write port indexed by that slot. Stores leave from the head, one per cycle and strictly in order, and only once the head store's address is known.

A load presents its address, its size and a queue position. The position is the tail value at the moment the load was dispatched, so every store below that position is older than the load. The block walks the older stores from youngest to oldest. It stops at the first store whose address is unknown, or at the first store whose bytes overlap the load. The answer is forward (with that store's data), wait, or read the cache.

A flush input takes a queue position and drops every store allocated at or after it in one cycle. This recovers from a mispredicted branch whose tail snapshot is that position.

Top module: `store_queue_check`

## Requirements
- R1: After reset the queue is empty: alloc_ready is 1, ret_valid is 0, alloc_pos is 0, and a load at the tail position gets result 0 (cache).
- R2: Each accepted allocation returns alloc_pos, then alloc_pos moves up by one. When DEPTH stores are outstanding, alloc_ready is 0 and an allocation request has no effect.
- R3: Stores retire from the head strictly in allocation order, one per cycle with ret_valid and ret_ready both high. ret_valid stays 0 while the head store's address is unknown, even if younger stores are known.
- R4: If the youngest older overlapping store is a word store (size code 2) at the same word-aligned address as a word load, the result is 1 (forward) and ld_data carries that store's data. When several older stores match, the youngest one wins.
- R5: Only stores at positions below ld_pos and at or above the head are candidates. A load whose position equals the head gets result 0.
- R6: If an unknown-address store is met in the youngest-to-oldest walk before any overlapping store, the result is 2 (wait). This includes the case where no known store overlaps.
- R7: An unknown-address store that is older than the youngest overlapping store does not change the answer.
- R8: Size codes are 0 byte, 1 halfword, 2 word, and accesses are naturally aligned. A byte overlap that is not an exact aligned word match gives 2 (wait). No overlap with any older store, and no unknown older store, gives 0 (cache).
- R9: A flush at position P sets the next allocation position to P, discards all younger stores, and frees their slots. A slot that is allocated again starts with an unknown address.
- R10: Positions carry one wrap bit above the slot index, so full and empty stay distinct and lookups stay correct after the slot index wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request a slot for a new store |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_pos | output | IW+1 | Position given to the next allocated store |
| st_wr_valid | input | 1 | Write address, size and data into a slot |
| st_wr_idx | input | IW | Slot index being written |
| st_wr_addr | input | AW | Store byte address |
| st_wr_size | input | 2 | Store size code |
| st_wr_data | input | 32 | Store data |
| ret_valid | output | 1 | Head store is known and may retire |
| ret_ready | input | 1 | Memory accepts the head store |
| ret_addr | output | AW | Head store address |
| ret_size | output | 2 | Head store size code |
| ret_data | output | 32 | Head store data |
| ld_valid | input | 1 | Load lookup is being presented |
| ld_pos | input | IW+1 | Tail snapshot taken when the load was dispatched |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_result | output | 2 | 0 cache, 1 forward, 2 wait |
| ld_data | output | 32 | Forwarded data when result is 1 |
| flush_valid | input | 1 | Discard younger stores |
| flush_pos | input | IW+1 | First position to discard |

## Verification
The bench builds the block with its defaults: eight slots, four-bit positions and 32-bit addresses. With this small depth, filling the queue after a partial drain takes the tail through the slot-index wrap, so the full condition, the flush and the lookups across the wrap all occur within a few dozen cycles. The 32-bit width makes every comparator span the whole address. The lookup vectors place matching, partially overlapping and unknown stores on both sides of each load position.

// File: rtl/store_queue_check.sv
module store_queue_check #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  output logic [$clog2(DEPTH):0]     alloc_pos,
  input  logic                       st_wr_valid,
  input  logic [$clog2(DEPTH)-1:0]   st_wr_idx,
  input  logic [AW-1:0]              st_wr_addr,
  input  logic [1:0]                 st_wr_size,
  input  logic [31:0]                st_wr_data,
  output logic                       ret_valid,
  input  logic                       ret_ready,
  output logic [AW-1:0]              ret_addr,
  output logic [1:0]                 ret_size,
  output logic [31:0]                ret_data,
  input  logic                       ld_valid,
  input  logic [$clog2(DEPTH):0]     ld_pos,
  input  logic [AW-1:0]              ld_addr,
  input  logic [1:0]                 ld_size,
  output logic [1:0]                 ld_result,
  output logic [31:0]                ld_data,
  input  logic                       flush_valid,
  input  logic [$clog2(DEPTH):0]     flush_pos
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;
  localparam logic [1:0] RES_CACHE = 2'd0;
  localparam logic [1:0] RES_FWD   = 2'd1;
  localparam logic [1:0] RES_WAIT  = 2'd2;
  localparam logic [1:0] SZ_WORD   = 2'd2;

  logic [PW-1:0]    head, tail, count;
  logic [DEPTH-1:0] known;
  logic [AW-1:0]    q_addr [DEPTH];
  logic [1:0]       q_size [DEPTH];
  logic [31:0]      q_data [DEPTH];
  logic             alloc_fire, ret_fire;

  function automatic logic [3:0] bmask(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    bmask = 4'b0001 << lo;
      2'd1:    bmask = 4'b0011 << {lo[1], 1'b0};
      default: bmask = 4'b1111;
    endcase
  endfunction

  assign count       = tail - head;
  assign alloc_ready = (count != PW'(DEPTH));
  assign alloc_pos   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign ret_valid   = (count != '0) && known[head[IW-1:0]];
  assign ret_fire    = ret_valid && ret_ready;
  assign ret_addr    = q_addr[head[IW-1:0]];
  assign ret_size    = q_size[head[IW-1:0]];
  assign ret_data    = q_data[head[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      known <= '0;
    end else begin
      if (ret_fire) head <= head + 1'b1;
      if (flush_valid) tail <= flush_pos;
      else if (alloc_fire) begin
        tail <= tail + 1'b1;
        known[tail[IW-1:0]] <= 1'b0;
      end
      if (st_wr_valid) known[st_wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_wr_valid) begin
      q_addr[st_wr_idx] <= st_wr_addr;
      q_size[st_wr_idx] <= st_wr_size;
      q_data[st_wr_idx] <= st_wr_data;
    end
  end

  logic [PW-1:0] older;
  assign older = ld_pos - head;

  always_comb begin
    logic          hit;
    logic [IW-1:0] idx;
    logic [PW-1:0] p;
    hit       = 1'b0;
    p         = '0;
    idx       = '0;
    ld_result = RES_CACHE;
    ld_data   = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      p   = ld_pos - PW'(k);
      idx = p[IW-1:0];
      if (!hit && PW'(k) <= older) begin
        if (!known[idx]) begin
          hit       = 1'b1;
          ld_result = RES_WAIT;
        end else if (q_addr[idx][AW-1:2] == ld_addr[AW-1:2] &&
                     |(bmask(q_size[idx], q_addr[idx][1:0]) & bmask(ld_size, ld_addr[1:0]))) begin
          hit = 1'b1;
          if (q_size[idx] == SZ_WORD && ld_size == SZ_WORD &&
              q_addr[idx] == ld_addr && ld_addr[1:0] == 2'b00) begin
            ld_result = RES_FWD;
            ld_data   = q_data[idx];
          end else begin
            ld_result = RES_WAIT;
          end
        end
      end
    end
  end

  a_r1_empty_reads_cache: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && ld_pos == tail) |-> ld_result == RES_CACHE);

  a_r2_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !flush_valid) |=> alloc_pos == $past(alloc_pos));

  a_r3_no_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !ret_valid);

  a_r4_forward_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_result == RES_FWD) |-> (ld_size == SZ_WORD && ld_addr[1:0] == 2'b00));

  a_r5_load_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> older <= count);

  a_r9_flush_moves_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> alloc_pos == $past(flush_pos));

  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
endmodule

// File: tb/sim_store_queue_check.sv
module sim_store_queue_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [3:0]  alloc_pos;
  logic        st_wr_valid = 1'b0;
  logic [2:0]  st_wr_idx = '0;
  logic [31:0] st_wr_addr = '0;
  logic [1:0]  st_wr_size = '0;
  logic [31:0] st_wr_data = '0;
  logic        ret_valid;
  logic        ret_ready = 1'b0;
  logic [31:0] ret_addr;
  logic [1:0]  ret_size;
  logic [31:0] ret_data;
  logic        ld_valid = 1'b0;
  logic [3:0]  ld_pos = '0;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic [1:0]  ld_result;
  logic [31:0] ld_data;
  logic        flush_valid = 1'b0;
  logic [3:0]  flush_pos = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  store_queue_check u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_pos(alloc_pos),
    .st_wr_valid(st_wr_valid), .st_wr_idx(st_wr_idx), .st_wr_addr(st_wr_addr),
    .st_wr_size(st_wr_size), .st_wr_data(st_wr_data),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_addr(ret_addr),
    .ret_size(ret_size), .ret_data(ret_data),
    .ld_valid(ld_valid), .ld_pos(ld_pos), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_result(ld_result), .ld_data(ld_data),
    .flush_valid(flush_valid), .flush_pos(flush_pos)
  );

  typedef struct packed {
    logic [3:0]  pos;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [1:0]  res;
    logic [31:0] dat;
  } vec_t;

  localparam vec_t VT [11] = '{
    '{4'd6, 32'h100, 2'd2, 2'd1, 32'hA3},  // R4 R7: youngest match wins past unknown p2
    '{4'd3, 32'h100, 2'd2, 2'd2, 32'h0},   // R6: unknown p2 is youngest older
    '{4'd2, 32'h100, 2'd2, 2'd1, 32'hA0},  // R5: younger p3 ignored
    '{4'd6, 32'h200, 2'd2, 2'd2, 32'h0},   // R8: half store overlaps word load
    '{4'd6, 32'h204, 2'd2, 2'd2, 32'h0},   // R6: no overlap but unknown older
    '{4'd2, 32'h400, 2'd2, 2'd0, 32'h0},   // R8: no overlap, all known
    '{4'd6, 32'h300, 2'd2, 2'd1, 32'hA5},  // R4
    '{4'd6, 32'h301, 2'd0, 2'd2, 32'h0},   // R8: byte inside word store
    '{4'd0, 32'h100, 2'd2, 2'd0, 32'h0},   // R5: nothing older
    '{4'd2, 32'h200, 2'd2, 2'd1, 32'hA1},  // R4
    '{4'd4, 32'h102, 2'd1, 2'd2, 32'h0}    // R8: half load inside word store
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic st_write(input logic [2:0] idx, input logic [31:0] a,
                          input logic [1:0] s, input logic [31:0] d);
    st_wr_valid = 1'b1; st_wr_idx = idx; st_wr_addr = a; st_wr_size = s; st_wr_data = d;
    @(negedge clk);
    st_wr_valid = 1'b0;
  endtask

  task automatic look(input logic [3:0] p, input logic [31:0] a, input logic [1:0] s);
    ld_valid = 1'b1; ld_pos = p; ld_addr = a; ld_size = s;
    #1;
  endtask

  task automatic retire_one(input string req, input logic [31:0] ea, input logic [31:0] ed);
    chk({req, " ret_valid"}, 64'(ret_valid), 64'd1);
    chk({req, " ret_addr"}, 64'(ret_addr), 64'(ea));
    chk({req, " ret_data"}, 64'(ret_data), 64'(ed));
    ret_ready = 1'b1;
    @(negedge clk);
    ret_ready = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R1 ret_valid", 64'(ret_valid), 64'd0);
    chk("R1 alloc_pos", 64'(alloc_pos), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    look(4'd0, 32'h100, 2'd2);
    chk("R1 empty lookup", 64'(ld_result), 64'd0);
    ld_valid = 1'b0;

    alloc_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R2 alloc_pos sequence", 64'(alloc_pos), 64'(i));
      @(negedge clk);
    end
    alloc_valid = 1'b0;
    st_write(3'd0, 32'h100, 2'd2, 32'hA0);
    st_write(3'd1, 32'h200, 2'd2, 32'hA1);
    st_write(3'd3, 32'h100, 2'd2, 32'hA3);
    st_write(3'd4, 32'h202, 2'd1, 32'hA4);
    st_write(3'd5, 32'h300, 2'd2, 32'hA5);

    for (int v = 0; v < 11; v++) begin
      look(VT[v].pos, VT[v].addr, VT[v].sz);
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d result", v), 64'(ld_result), 64'(VT[v].res));
      if (VT[v].res == 2'd1)
        chk($sformatf("R4 vector %0d data", v), 64'(ld_data), 64'(VT[v].dat));
      @(negedge clk);
    end
    ld_valid = 1'b0;

    #1;
    retire_one("R3 head p0", 32'h100, 32'hA0);
    retire_one("R3 head p1", 32'h200, 32'hA1);
    chk("R3 unknown head blocks retire", 64'(ret_valid), 64'd0);
    @(negedge clk);
    st_write(3'd2, 32'h500, 2'd2, 32'hA2);
    #1;
    retire_one("R3 head p2", 32'h500, 32'hA2);
    retire_one("R3 head p3", 32'h100, 32'hA3);
    retire_one("R3 head p4", 32'h202, 32'hA4);
    retire_one("R3 head p5", 32'h300, 32'hA5);
    chk("R3 drained", 64'(ret_valid), 64'd0);

    alloc_valid = 1'b1;
    for (int i = 6; i < 14; i++) begin
      #1;
      chk("R10 alloc_pos across wrap", 64'(alloc_pos), 64'(i));
      @(negedge clk);
    end
    #1;
    chk("R2 full", 64'(alloc_ready), 64'd0);
    @(negedge clk);
    alloc_valid = 1'b0;
    #1;
    chk("R2 alloc ignored when full", 64'(alloc_pos), 64'd14);
    st_write(3'd0, 32'h600, 2'd2, 32'hB0);
    st_write(3'd1, 32'h600, 2'd2, 32'hC0);
    flush_valid = 1'b1; flush_pos = 4'd9;
    @(negedge clk);
    flush_valid = 1'b0;
    #1;
    chk("R9 alloc_pos after flush", 64'(alloc_pos), 64'd9);
    chk("R9 slots freed", 64'(alloc_ready), 64'd1);
    look(4'd9, 32'h600, 2'd2);
    chk("R10 forward across wrap", 64'(ld_result), 64'd1);
    chk("R10 forward data", 64'(ld_data), 64'hB0);
    look(4'd9, 32'h604, 2'd2);
    chk("R6 unknown across wrap", 64'(ld_result), 64'd2);
    ld_valid = 1'b0;
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    look(4'd10, 32'h600, 2'd2);
    chk("R9 reallocated slot unknown", 64'(ld_result), 64'd2);
    ld_valid = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule